// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog that escalates in two stages. A down-counter, advanced only by a one-cycle tick-enable input, is loaded from a programmable timeout of up to 48 bits. If the timeout runs out without a refresh, the first stage flag rises. This flag is meant to interrupt software. The counter then starts a second period of the same length. If that period also runs out without a refresh, the second stage flag rises. This flag is meant to drive a system reset request.

Software reaches the block over a simple register bus split into two frames. The refresh frame holds a single refresh word: writing any value to it restarts the period. The control frame holds the control/status word, the timeout split into low and high words, and a read-only identification word. The bus has no back-pressure. Every request is taken in the cycle it is presented. A read returns its data exactly one cycle later, marked by a one-cycle valid pulse. Writes produce no response.

A refresh that lands in the same cycle as an expiry always wins. The first stage flag ends up clear, the second stage flag is not raised, and a full period begins.

Top module: `wdg_two_stage`

## Requirements
- R1: After reset both stage outputs are low, the control/status word reads 0 and the counter does not run.
- R2: Once enabled with timeout value T, the first stage output rises on the (T+1)-th tick after the enabling write, and not before. T = 0 expires on the first tick.
- R3: With no refresh, the second stage output rises on the (T+1)-th tick after the first stage rose, and only while the first stage output is set.
- R4: A write of any value to the refresh frame (bus_frame = 0) clears the first stage output in the same edge and restarts a full T+1 tick period.
- R5: A refresh write in the same cycle as an expiry tick takes priority. The first stage output is clear afterwards, the second stage output does not rise, and the next expiry comes T+1 ticks later.
- R6: While disabled, ticks have no effect and both stage outputs hold. A write that sets the enable bit while it is clear reloads the counter with T.
- R7: The second stage output stays set until block reset. Neither a refresh nor clearing the enable bit clears it.
- R8: Writing either timeout word while enabled clears the first stage output and reloads the counter with the new timeout value.
- R9: The identification word (control frame, word 3) reads the architecture version in bits 19:16 and the implementer code in bits 10:0. All other bits read 0.
- R10: Control frame word 0 is control/status: bit 0 is enable (read/write), bit 1 is the first stage flag and bit 2 is the second stage flag. Word 1 holds timeout bits 31:0 and word 2 holds timeout bits 47:32 in its bits 15:0. Unused bits read 0.
- R11: A read request (bus_valid = 1, bus_write = 0) gives bus_rvalid = 1 with the data in the next cycle only. A read of the refresh frame returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse that advances the counter |
| bus_valid | input | 1 | Bus request present (always accepted) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = refresh frame, 1 = control frame |
| bus_addr | input | 2 | Word index inside the control frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read-return strobe |
| ws0_irq | output | 1 | First stage flag (interrupt request) |
| ws1_rst_req | output | 1 | Second stage flag (reset request) |

## Verification
Every write and every tick takes effect on the clock edge that samples it. The stage outputs are therefore due on the same edge as the expiring tick or the refresh, and read data is due one edge after the read request. The bench drives inputs on the falling edge and compares outputs on the next falling edge, one registered step later. The timeout sweeps check the stage outputs after every single tick. This pins each expiry to exactly tick T+1, and the race cases put the refresh and the expiring tick in the very same sampled cycle.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  localparam int unsigned CSR_AW = 2;

  typedef enum logic [CSR_AW-1:0] {
    CSR_CTRL   = 2'd0,
    CSR_OFF_LO = 2'd1,
    CSR_OFF_HI = 2'd2,
    CSR_IDENT  = 2'd3
  } csr_e;

  localparam logic FRAME_REFRESH = 1'b0;
  localparam logic FRAME_CONTROL = 1'b1;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_S0_BIT = 1;
  localparam int unsigned CTRL_S1_BIT = 2;
  localparam int unsigned ID_VER_LSB  = 16;

  typedef struct packed {
    logic reload;
    logic clr_s0;
  } wdg_cmd_t;
endpackage

// File: rtl/wdg_regif.sv
`timescale 1ns/1ps
module wdg_regif
  import wdg_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 48,
  parameter logic [3:0]  ARCH_VER  = 4'h1,
  parameter logic [10:0] IMPL_CODE = 11'h2A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_frame,
  input  logic [CSR_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              s0,
  input  logic              s1,
  output logic              en,
  output logic [CNT_W-1:0]  load_val,
  output wdg_cmd_t          cmd,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int unsigned HI_W = CNT_W - DATA_W;
  localparam logic [DATA_W-1:0] IDENT =
    (DATA_W'(ARCH_VER) << ID_VER_LSB) | DATA_W'(IMPL_CODE);

  logic             wr_any, rd_any, refresh_wr, ctl_wr;
  logic             ctrl_wr, lo_wr, hi_wr, off_live, en_rise;
  logic             en_q;
  logic [CNT_W-1:0] off_q, off_d;
  logic [DATA_W-1:0] rd_next;
  csr_e             sel;

  assign sel        = csr_e'(bus_addr);
  assign wr_any     = bus_valid & bus_write;
  assign rd_any     = bus_valid & ~bus_write;
  assign refresh_wr = wr_any & (bus_frame == FRAME_REFRESH);
  assign ctl_wr     = wr_any & (bus_frame == FRAME_CONTROL);
  assign ctrl_wr    = ctl_wr & (sel == CSR_CTRL);
  assign lo_wr      = ctl_wr & (sel == CSR_OFF_LO);
  assign hi_wr      = ctl_wr & (sel == CSR_OFF_HI);
  assign off_live   = (lo_wr | hi_wr) & en_q;
  assign en_rise    = ctrl_wr & bus_wdata[CTRL_EN_BIT] & ~en_q;

  // Refresh outranks everything downstream: it reloads and clears stage 0.
  assign cmd.reload = refresh_wr | en_rise | off_live;
  assign cmd.clr_s0 = refresh_wr | off_live;

  always_comb begin
    off_d = off_q;
    if (lo_wr) off_d[DATA_W-1:0] = bus_wdata;
    if (hi_wr) off_d[CNT_W-1:DATA_W] = bus_wdata[HI_W-1:0];
  end

  // Counter loads the value being written this cycle, not the stale one.
  assign load_val = off_d;
  assign en       = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      off_q <= '0;
    end else begin
      off_q <= off_d;
      if (ctrl_wr) en_q <= bus_wdata[CTRL_EN_BIT];
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_frame == FRAME_CONTROL) begin
      unique case (sel)
        CSR_CTRL:   rd_next = DATA_W'({s1, s0, en_q});
        CSR_OFF_LO: rd_next = off_q[DATA_W-1:0];
        CSR_OFF_HI: rd_next = DATA_W'(off_q[CNT_W-1:DATA_W]);
        CSR_IDENT:  rd_next = IDENT;
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_any;
      if (rd_any) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/wdg_counter.sv
`timescale 1ns/1ps
module wdg_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero, step;

  assign at_zero = (cnt_q == '0);
  assign step    = en & tick;
  // A reload in the same cycle suppresses the expiry.
  assign expire  = step & at_zero & ~reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (reload | expire) cnt_q <= load_val;
    else if (step)            cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdg_stage.sv
`timescale 1ns/1ps
module wdg_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_s0,
  output logic s0,
  output logic s1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      if (clr_s0)              s0 <= 1'b0;
      else if (expire)         s0 <= 1'b1;
      if (expire & s0 & ~clr_s0) s1 <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_two_stage.sv
`timescale 1ns/1ps
module wdg_two_stage
  import wdg_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 48,
  parameter logic [3:0]  ARCH_VER  = 4'h1,
  parameter logic [10:0] IMPL_CODE = 11'h2A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_frame,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              ws0_irq,
  output logic              ws1_rst_req
);
  logic             ctrl_en, expire, s0, s1;
  logic [CNT_W-1:0] load_val;
  wdg_cmd_t         cmd;

  wdg_regif #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ARCH_VER(ARCH_VER), .IMPL_CODE(IMPL_CODE)
  ) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .s0(s0), .s1(s1),
    .en(ctrl_en), .load_val(load_val), .cmd(cmd),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick_en),
    .reload(cmd.reload), .load_val(load_val), .expire(expire)
  );

  wdg_stage u_stage (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_s0(cmd.clr_s0),
    .s0(s0), .s1(s1)
  );

  assign ws0_irq     = s0;
  assign ws1_rst_req = s1;
endmodule

// File: rtl/wdg_two_stage_chk.sv
`timescale 1ns/1ps
module wdg_two_stage_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_valid,
  input logic bus_write,
  input logic bus_frame,
  input logic bus_rvalid,
  input logic ctrl_en,
  input logic ws0,
  input logic ws1
);
  logic refresh_wr;
  assign refresh_wr = bus_valid & bus_write & (bus_frame == 1'b0);

  // R7
  ws1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ws1 |=> ws1);

  // R3
  ws1_needs_ws0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws1) |-> $past(ws0));

  // R4
  refresh_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_wr |=> !ws0);

  // R5
  refresh_blocks_ws1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_wr && !ws1) |=> !ws1);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !(bus_valid && bus_write)) |=> ($stable(ws0) && $stable(ws1)));

  // R11
  read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  // R11
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind wdg_two_stage wdg_two_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_frame(bus_frame), .bus_rvalid(bus_rvalid), .ctrl_en(ctrl_en),
  .ws0(ws0_irq), .ws1(ws1_rst_req)
);

// File: tb/wdg_two_stage_test.sv
`timescale 1ns/1ps
module wdg_two_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic        bus_frame = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, ws0_irq, ws1_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd;

  localparam logic [31:0] EXP_ID = (32'h1 << 16) | 32'h2A5;

  always #10 clk = ~clk;

  wdg_two_stage uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ws0_irq(ws0_irq), .ws1_rst_req(ws1_rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic v, input logic w, input logic f,
                     input logic [1:0] a, input logic [31:0] d);
    tick_en = t; bus_valid = v; bus_write = w; bus_frame = f;
    bus_addr = a; bus_wdata = d;
    @(negedge clk);
    tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(input logic f, input logic [1:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, 1'b1, f, a, d);
  endtask

  task automatic rdreg(input logic f, input logic [1:0] a, output logic [31:0] d);
    cyc(1'b0, 1'b1, 1'b0, f, a, 32'h0);
    chk("R11 rvalid", 32'(bus_rvalid), 32'h1);
    d = bus_rdata;
  endtask

  task automatic tick1();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Tick k+1 times; the selected stage must rise exactly on the last tick.
  task automatic expect_expiry(input int k, input logic stage1, input string req);
    for (int i = 1; i <= k + 1; i++) begin
      tick1();
      chk(req, 32'(stage1 ? ws1_rst_req : ws0_irq), 32'(i == k + 1));
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 ws0", 32'(ws0_irq), 32'h0);
    chk("R1 ws1", 32'(ws1_rst_req), 32'h0);
    rdreg(1'b1, 2'd0, rd);
    chk("R1 ctrl", rd, 32'h0);
    for (int i = 0; i < 4; i++) tick1();
    chk("R1 idle", 32'(ws0_irq), 32'h0);
    // R9 identification
    rdreg(1'b1, 2'd3, rd);
    chk("R9 ident", rd, EXP_ID);
    @(negedge clk);
    chk("R11 rvalid drop", 32'(bus_rvalid), 32'h0);
    rdreg(1'b0, 2'd0, rd);
    chk("R11 refresh read", rd, 32'h0);

    // R2/R3 sweep over timeouts, with gaps between ticks on odd values
    for (int k = 0; k <= 6; k++) begin
      do_reset();
      wr(1'b1, 2'd1, 32'(k));
      wr(1'b1, 2'd0, 32'h1);
      for (int i = 1; i <= k + 1; i++) begin
        tick1();
        if (k % 2 == 1) cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
        chk("R2 ws0 timing", 32'(ws0_irq), 32'(i == k + 1));
      end
      expect_expiry(k, 1'b1, "R3 ws1 timing");
      chk("R3 ws0 held", 32'(ws0_irq), 32'h1);
      rdreg(1'b1, 2'd0, rd);
      chk("R10 ctrl bits", rd, 32'h7);
    end

    // R4 refresh with arbitrary data
    do_reset();
    wr(1'b1, 2'd1, 32'd3);
    wr(1'b1, 2'd0, 32'h1);
    expect_expiry(3, 1'b0, "R2 ws0");
    wr(1'b0, 2'd2, 32'hDEAD_BEEF);
    chk("R4 clear", 32'(ws0_irq), 32'h0);
    expect_expiry(3, 1'b0, "R4 full period");
    chk("R4 no ws1", 32'(ws1_rst_req), 32'h0);

    // R5 refresh in the expiry cycle
    do_reset();
    wr(1'b1, 2'd1, 32'd2);
    wr(1'b1, 2'd0, 32'h1);
    tick1(); tick1();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0);
    chk("R5 s0 race", 32'(ws0_irq), 32'h0);
    expect_expiry(2, 1'b0, "R5 restart");
    tick1(); tick1();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h5);
    chk("R5 s1 race", 32'(ws1_rst_req), 32'h0);
    chk("R5 s0 clear", 32'(ws0_irq), 32'h0);
    expect_expiry(2, 1'b0, "R5 restart2");
    chk("R5 no ws1", 32'(ws1_rst_req), 32'h0);

    // R6 disabled hold and reload on enable
    do_reset();
    wr(1'b1, 2'd1, 32'd4);
    for (int i = 0; i < 10; i++) tick1();
    chk("R6 disabled", 32'(ws0_irq), 32'h0);
    wr(1'b1, 2'd0, 32'h1);
    tick1(); tick1();
    wr(1'b1, 2'd0, 32'h0);
    for (int i = 0; i < 8; i++) tick1();
    chk("R6 held", 32'(ws0_irq), 32'h0);
    wr(1'b1, 2'd0, 32'h1);
    expect_expiry(4, 1'b0, "R6 reload");
    wr(1'b1, 2'd0, 32'h0);
    for (int i = 0; i < 10; i++) tick1();
    chk("R6 s0 hold", 32'(ws0_irq), 32'h1);
    chk("R6 s1 hold", 32'(ws1_rst_req), 32'h0);
    wr(1'b1, 2'd0, 32'h1);
    expect_expiry(4, 1'b1, "R6 ws1 after reenable");

    // R7 sticky second stage
    wr(1'b0, 2'd0, 32'h0);
    chk("R7 refresh", 32'(ws1_rst_req), 32'h1);
    wr(1'b1, 2'd0, 32'h0);
    chk("R7 disable", 32'(ws1_rst_req), 32'h1);
    rdreg(1'b1, 2'd0, rd);
    chk("R7 ctrl", rd, 32'h4);
    do_reset();
    chk("R7 reset", 32'(ws1_rst_req), 32'h0);

    // R8 timeout write while enabled, R10 timeout readback
    wr(1'b1, 2'd1, 32'd5);
    wr(1'b1, 2'd0, 32'h1);
    expect_expiry(5, 1'b0, "R8 first");
    tick1(); tick1(); tick1();
    wr(1'b1, 2'd1, 32'd1);
    chk("R8 clear", 32'(ws0_irq), 32'h0);
    expect_expiry(1, 1'b0, "R8 new period");
    wr(1'b1, 2'd2, 32'hFFFF_ABCD);
    chk("R8 hi clear", 32'(ws0_irq), 32'h0);
    rdreg(1'b1, 2'd2, rd);
    chk("R10 off hi", rd, 32'h0000_ABCD);
    rdreg(1'b1, 2'd1, rd);
    chk("R10 off lo", rd, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule